// File: doc/BRIEF.md
# Flash Bank Status Read Encoder

This block forms the word a flash bank returns on reads while one of its internal program or erase sequences runs. It sits between the array read path and the data output. When the bank is quiet, or the read is aimed at another bank, the array word goes straight through. When the bank is working, the block replaces the array word with a status pattern. Some bits of that pattern describe the operation. Other bits flip from one read to the next, so software can poll for completion.

The flipping bits advance once per completed read access. A read ends on the falling edge of the read strobe, and it counts only when the bank-match flag was high. A new operation clears them. Several cases change what the host sees: a program aimed at a protected sector produces a short burst of busy status and then returns to array data; erase suspend changes which bits flip; a timeout raises a sticky error bit. The sequencer that actually programs or erases is outside this block.

Top module: `flash_status_gen`

## Requirements
- R1: When the status view is not selected, `dout_o` equals `array_i` exactly. The status view is selected when `bank_hit_i` is high and at least one of these holds: `busy_i` is high, a protected-hit burst is running, or `susp_i` and `sel_sector_i` are both high. When the status view is selected, every bit other than 7, 6, 5, 3 and 2 reads 0.
- R2: Status bit 7 depends on the state:
  - `busy_i` high with `op_kind_i`=0 (program): it reads the inverse of `prog_d7_i`.
  - `busy_i` high with `op_kind_i`=1 (erase): it reads 0.
  - During a protected-hit burst: it reads the inverse of `prog_d7_i`.
  - During an erase-suspend read of a selected sector (`susp_i` high, `busy_i` low): it reads 1.
- R3: Status bit 6 shows a toggle flop. The flop inverts once for each qualified read that ends while `busy_i` is high or a burst runs. A qualified read ends on a clock where the previous cycle had `rd_i` and `bank_hit_i` both high and the current cycle does not. A read with `bank_hit_i` low has no effect on the flop.
- R4: A `prot_hit_i` pulse while `busy_i` is low and no burst is running starts a burst lasting exactly `PROT_CYCLES` clocks. During the burst the bank shows status, bit 6 toggles per read, and `rdy_o` is low. Afterwards the bank returns to array data.
- R5: Status bit 5 is set by `timeout_i` while `busy_i` is high. It stays set, including after the operation ends, until `clr_err_i` is asserted; `clr_err_i` takes precedence.
- R6: Status bit 3 reads 1 during a busy erase whose command window has closed (`win_open_i` low). It reads 0 in every other case.
- R7: Status bit 2 shows a second toggle flop. It inverts on a qualified read end only when `sel_sector_i` is high and either `susp_i` is high or a busy erase runs. During an erase-suspend read (`busy_i` low), bit 6 holds its value.
- R8: `rdy_o` is low exactly when `busy_i` is high or a burst runs.
- R9: `op_start_i` clears both toggle flops to 0 on the next clock edge.
- R10: After reset, `rdy_o` is 1, both toggle flops are 0, the error bit is 0, and no burst runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal operation running in this bank |
| op_kind_i | input | 1 | 0 program, 1 erase |
| prog_d7_i | input | 1 | Bit 7 of the word being programmed |
| prot_hit_i | input | 1 | Program command hit a protected sector (pulse) |
| timeout_i | input | 1 | Operation exceeded its time limit |
| clr_err_i | input | 1 | Reset command, clears the error bit |
| win_open_i | input | 1 | Erase command window still open |
| susp_i | input | 1 | Erase suspended |
| sel_sector_i | input | 1 | Read address lies in a sector selected for erase |
| op_start_i | input | 1 | New operation begins |
| rd_i | input | 1 | Read strobe |
| bank_hit_i | input | 1 | Read targets this bank |
| array_i | input | DATA_W | Array read data |
| dout_o | output | DATA_W | Data returned to the host |
| rdy_o | output | 1 | Ready (1) / busy (0) |

## Verification
The assertions check, on every cycle, several rules that hold at all times:
- the toggle flops hold still when no qualified read ends;
- `op_start_i` clears the toggle flops;
- the burst counter only counts down;
- the error bit is sticky;
- `rdy_o` is low while busy;
- a bank miss always passes array data.

Only the bench's scenarios can show the values the host sees across a sequence of reads. These include the exact length of a protected-hit burst and the bit 7 polarity in each mode. They also include which toggle bit moves in erase-suspend read versus erase-suspend program.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
   typedef enum logic {
      OPK_PROG  = 1'b0,
      OPK_ERASE = 1'b1
   } op_kind_e;

   localparam int SB_POLL  = 7;
   localparam int SB_TGL   = 6;
   localparam int SB_ERR   = 5;
   localparam int SB_WIN   = 3;
   localparam int SB_ESTGL = 2;
   localparam int SB_BYTE  = 8;
endpackage

// File: rtl/fs_read_edge.sv
module fs_read_edge #(
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_i,
   input  logic hit_i,
   output logic step_o
);
   logic qual;
   logic qual_q;

   assign qual = rd_i & hit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qual_q <= 1'b0;
      else        qual_q <= qual;
   end

   generate
      if (FALL_EDGE) begin : g_fall
         assign step_o = qual_q & ~qual;
      end else begin : g_rise
         assign step_o = ~qual_q & qual;
      end
   endgenerate
endmodule

// File: rtl/fs_toggle.sv
module fs_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic step_i,
   input  logic en_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              q_o <= 1'b0;
      else if (clr_i)          q_o <= 1'b0;
      else if (step_i && en_i) q_o <= ~q_o;
   end

   // R9
   tgl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !q_o);
   // R3
   tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !(step_i && en_i)) |=> $stable(q_o));
endmodule

// File: rtl/fs_burst.sv
module fs_burst #(
   parameter int CYCLES = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic active_o
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOADV = CW'(CYCLES);

   generate
      if (CYCLES < 1) begin : g_bad
         $error("fs_burst: CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (cnt != '0)            cnt <= cnt - 1'b1;
      else if (start_i)              cnt <= LOADV;
   end

   assign active_o = (cnt != '0);

   // R4
   burst_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
   // R4
   burst_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LOADV);
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import flash_status_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int PROT_CYCLES = 50,
   parameter bit FALL_EDGE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              op_kind_i,
   input  logic              prog_d7_i,
   input  logic              prot_hit_i,
   input  logic              timeout_i,
   input  logic              clr_err_i,
   input  logic              win_open_i,
   input  logic              susp_i,
   input  logic              sel_sector_i,
   input  logic              op_start_i,
   input  logic              rd_i,
   input  logic              bank_hit_i,
   input  logic [DATA_W-1:0] array_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              rdy_o
);
   localparam int NTGL = 2;

   generate
      if (DATA_W < SB_BYTE) begin : g_bad_w
         $error("flash_status_gen: DATA_W must be at least 8");
      end
   endgenerate

   logic            step;
   logic            burst;
   logic            err_q;
   logic            is_erase;
   logic [NTGL-1:0] tgl_en;
   logic [NTGL-1:0] tgl_q;
   logic            show_stat;
   logic [DATA_W-1:0] stat_w;

   assign is_erase = (op_kind_e'(op_kind_i) == OPK_ERASE);

   fs_read_edge #(.FALL_EDGE(FALL_EDGE)) u_edge (
      .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .hit_i(bank_hit_i), .step_o(step)
   );

   fs_burst #(.CYCLES(PROT_CYCLES)) u_burst (
      .clk(clk), .rst_n(rst_n), .start_i(prot_hit_i & ~busy_i), .active_o(burst)
   );

   assign tgl_en[0] = busy_i | burst;
   assign tgl_en[1] = sel_sector_i & (susp_i | (busy_i & is_erase));

   generate
      for (genvar g = 0; g < NTGL; g++) begin : g_tgl
         fs_toggle u_tgl (
            .clk(clk), .rst_n(rst_n), .clr_i(op_start_i),
            .step_i(step), .en_i(tgl_en[g]), .q_o(tgl_q[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  err_q <= 1'b0;
      else if (clr_err_i)          err_q <= 1'b0;
      else if (timeout_i && busy_i) err_q <= 1'b1;
   end

   always_comb begin
      stat_w = '0;
      if (busy_i)     stat_w[SB_POLL] = is_erase ? 1'b0 : ~prog_d7_i;
      else if (burst) stat_w[SB_POLL] = ~prog_d7_i;
      else            stat_w[SB_POLL] = 1'b1;
      stat_w[SB_TGL]   = tgl_q[0];
      stat_w[SB_ERR]   = err_q;
      stat_w[SB_WIN]   = busy_i & is_erase & ~win_open_i;
      stat_w[SB_ESTGL] = tgl_q[1];
   end

   assign show_stat = bank_hit_i & (busy_i | burst | (susp_i & sel_sector_i));
   assign dout_o    = show_stat ? stat_w : array_i;
   assign rdy_o     = ~(busy_i | burst);

   // R5
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !clr_err_i) |=> err_q);
   // R8
   busy_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> !rdy_o);
   // R1
   miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_hit_i |-> (dout_o == array_i));
endmodule

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
   localparam int DW = 16;
   localparam int PC = 50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic busy = 0, opk = 0, d7 = 0, phit = 0, tmo = 0, clr = 0, wopen = 1;
   logic susp = 0, sel = 0, start = 0, rd = 0, hit = 0;
   logic [DW-1:0] arr = 16'h1234;
   logic [DW-1:0] dout;
   logic rdy;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   flash_status_gen #(.DATA_W(DW), .PROT_CYCLES(PC)) u_flash_status_gen (
      .clk(clk), .rst_n(rst_n), .busy_i(busy), .op_kind_i(opk), .prog_d7_i(d7),
      .prot_hit_i(phit), .timeout_i(tmo), .clr_err_i(clr), .win_open_i(wopen),
      .susp_i(susp), .sel_sector_i(sel), .op_start_i(start), .rd_i(rd),
      .bank_hit_i(hit), .array_i(arr), .dout_o(dout), .rdy_o(rdy)
   );

   // reference model state
   bit m_t6, m_t2, m_err, m_prev;
   int m_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_t6 = 0; m_t2 = 0; m_err = 0; m_prev = 0; m_cnt = 0;
      end else begin
         bit q, fall, bur;
         q = rd & hit;
         fall = m_prev & ~q;
         m_prev = q;
         bur = (m_cnt != 0);
         if (start) begin m_t6 = 0; m_t2 = 0; end
         else if (fall) begin
            if (busy || bur) m_t6 = ~m_t6;
            if (sel && (susp || (busy && opk))) m_t2 = ~m_t2;
         end
         if (clr) m_err = 0;
         else if (tmo && busy) m_err = 1;
         if (m_cnt > 0) m_cnt = m_cnt - 1;
         else if (phit && !busy) m_cnt = PC;
      end
   end

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit vis, bur;
         bur = (m_cnt != 0);
         vis = hit & (busy | bur | (susp & sel));
         chk("R8 rdy", {15'd0, rdy}, {15'd0, ~(busy | bur)});
         if (!vis) chk("R1 pass", dout, arr);
         else begin
            logic e7;
            if (busy) e7 = opk ? 1'b0 : ~d7;
            else if (bur) e7 = ~d7;
            else e7 = 1'b1;
            chk("R1 pad", dout & 16'hFF13, 16'h0);
            chk("R2 dq7", {15'd0, dout[7]}, {15'd0, e7});
            chk("R3 dq6", {15'd0, dout[6]}, {15'd0, m_t6});
            chk("R5 dq5", {15'd0, dout[5]}, {15'd0, m_err});
            chk("R6 dq3", {15'd0, dout[3]}, {15'd0, busy & opk & ~wopen});
            chk("R7 dq2", {15'd0, dout[2]}, {15'd0, m_t2});
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic rdp(input logic h);
      hit = h; rd = 1; arr = arr + 16'h0111; step(2);
      rd = 0; step(2);
      hit = 1;
   endtask

   initial begin
      #200000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int lowc;
      step(3);
      rst_n = 1; step(1);
      @(negedge clk);
      // R10 reset state
      chk("R10 rdy", {15'd0, rdy}, 16'd1);
      hit = 1; #1;
      chk("R10 array", dout, arr);
      step(1);
      rdp(1); rdp(0);
      // program, d7=1
      start = 1; step(1); start = 0;
      busy = 1; opk = 0; d7 = 1;
      repeat (3) rdp(1);
      rdp(0); rdp(1);
      d7 = 0; rdp(1);
      busy = 0; rdp(1);
      // erase
      start = 1; step(1); start = 0;
      @(negedge clk);
      // R9 toggles cleared
      chk("R9 dq6", {15'd0, m_t6}, 16'd0);
      step(0);
      busy = 1; opk = 1; wopen = 1; sel = 1;
      rdp(1); wopen = 0; rdp(1); rdp(1);
      sel = 0; rdp(1); sel = 1;
      tmo = 1; step(1); tmo = 0;
      rdp(1);
      busy = 0; rdp(1);
      clr = 1; step(1); clr = 0;
      // suspend read
      susp = 1; sel = 1; rdp(1); rdp(1); sel = 0; rdp(1);
      // suspend program
      busy = 1; opk = 0; sel = 1; d7 = 1; rdp(1); rdp(1);
      busy = 0; susp = 0; sel = 0; step(2);
      // protected hit burst
      start = 1; step(1); start = 0;
      phit = 1; d7 = 0; step(1); phit = 0;
      rdp(1); rdp(1);
      step(PC);
      rdp(1);
      // R4 burst length counted independently
      phit = 1; step(1); phit = 0;
      @(negedge clk);
      lowc = 0;
      while (!rdy && lowc < 4 * PC) begin
         lowc++;
         @(negedge clk);
      end
      chk("R4 burst length", 16'(lowc), 16'(PC));
      step(3);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule